// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous request/acknowledge bus inside the chip and an external asynchronous static RAM of 64K words by 16 bits. The RAM has one active-low byte strobe per 8-bit lane. A requester presents a read or write request with a word address, write data and a per-lane mask, and holds it until the controller acknowledges it. The controller then steps the RAM's chip select, output enable, write enable, byte strobes and address through a fixed sequence of phases. Each phase lasts an integer number of system clock cycles. That number is derived at elaboration time from the clock period and the memory's nanosecond limits: the ceiling of the limit divided by the period, and never less than one cycle.

The data bus leaves the block as three signals: an output word, a pad drive enable and an input word. The pad ring combines them into the tri-stated bidirectional pins. The controller drives the bus only while a write strobe is active. After a read, it holds back any write until the RAM's outputs have had time to float. A read's result comes back on `rd_data` with a one-cycle `rd_valid` pulse. Only one request is in flight at a time.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sram_cs_n`, `sram_oe_n`, `sram_we_n` and every `sram_be_n` bit are 1, and `sram_dq_oe`, `req_ack` and `rd_valid` are 0.
- R2: Outside an access the RAM is deselected: `sram_cs_n` is 1, all `sram_be_n` bits are 1, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` is 0.
- R3: A read with a nonzero mask holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_CYC = ceil(T_RC_NS/CLK_NS) cycles (minimum 1), starting in the cycle `req_ack` is high. `sram_be_n[i]` is the inverse of `req_mask[i]`, where bit 0 is data bits 7:0.
- R4: The RAM data is sampled in the last read cycle. `rd_valid` is high for exactly the next cycle. In that cycle, lane i of `rd_data` equals lane i of `sram_dq_in` when mask bit i was set, and 0 otherwise.
- R5: A write with a nonzero mask runs in three parts. First comes one setup cycle with `sram_cs_n`=0 and `sram_we_n`=1. Next, `sram_we_n`=0 for WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles. Last come REC_CYC = max(1, ceil(T_WC_NS/CLK_NS) - WP_CYC - 1) cycles with `sram_cs_n`=0 and `sram_we_n`=1.
- R6: `sram_dq_oe` is 1 exactly in the cycles of a write where `sram_we_n` is 0. In those cycles `sram_dq_out` equals the request's write data.
- R7: During every cycle of a write, `sram_be_n[i]` is the inverse of `req_mask[i]`, so only the lanes that are set are written.
- R8: While `sram_cs_n` is 0, `sram_addr` equals the request address and neither it nor `sram_be_n` changes.
- R9: After a read, a write request is acknowledged no earlier than TA_CYC+1 cycles after the `rd_valid` cycle, where TA_CYC = ceil(T_HZ_NS/CLK_NS). A request raised in the `rd_valid` cycle is acknowledged at exactly that point. A read is not delayed this way.
- R10: `req_ack` is a one-cycle pulse, one cycle after acceptance. Requests are accepted only when the controller is idle. A request raised in an idle cycle that is not held back by R9 is acknowledged in the next cycle.
- R11: A request with mask 0 is acknowledged without taking `sram_cs_n` low and leaves the RAM unchanged. If it is a read, `rd_valid` is high with `rd_data`=0 in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane select, bit 0 = bits 7:0 |
| req_ack | output | 1 | One-cycle acceptance pulse |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result, unselected lanes zero |
| sram_addr | output | ADDR_W | RAM address lines |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_be_n | output | DATA_W/8 | RAM byte strobes, active low |
| sram_dq_out | output | DATA_W | Value for the data pads |
| sram_dq_oe | output | 1 | Pad drive enable for the data bus |
| sram_dq_in | input | DATA_W | Value read from the data pads |

## Verification
The bench walks a range of addresses with every nonzero mask, writing and then reading back each lane pattern. It counts the length of each phase against the cycle numbers it derives from the nanosecond limits. A controller that counted one cycle short or long, or that asserted the write strobe together with the address, would show a wrong phase count. The order of accesses makes every write after a read wait out the float gap. A missing or mis-sized gap therefore shows up as the wrong acknowledge latency, and a gap applied to reads as well shows up as slow read-after-read acknowledges. Reads with a single lane selected check that the deselected lane comes back zero rather than whatever floats on the bus. Zero-mask requests check that nothing is strobed and the stored word survives.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_RACC
  } asram_st_e;

  // ceiling of a nanosecond limit over the clock period, at least one cycle
  function automatic int ns2cyc(input int lim_ns, input int clk_ns);
    int c;
    c = (lim_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_tmr.sv
`timescale 1ns/1ps
module asram_tmr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq import asram_pkg::*; #(
  parameter int PH_W    = 4,
  parameter int RD_CYC  = 1,
  parameter int WP_CYC  = 1,
  parameter int REC_CYC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_null,
  input  logic            ack_q,
  input  logic            gap_zero,
  input  logic            ph_zero,
  output asram_st_e       st_nxt,
  output logic            ph_load,
  output logic [PH_W-1:0] ph_val,
  output logic            gap_load,
  output logic            accept,
  output logic            start,
  output logic            null_rd,
  output logic            capture
);

  asram_st_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  always_comb begin
    st_nxt   = st;
    ph_load  = 1'b0;
    ph_val   = '0;
    gap_load = 1'b0;
    accept   = 1'b0;
    start    = 1'b0;
    null_rd  = 1'b0;
    capture  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid && !ack_q && (!req_write || gap_zero)) begin
          accept = 1'b1;
          if (req_null) begin
            null_rd = !req_write;
          end else begin
            start = 1'b1;
            if (req_write) begin
              st_nxt = ST_WSET;
            end else begin
              st_nxt  = ST_RACC;
              ph_load = 1'b1;
              ph_val  = PH_W'(RD_CYC - 1);
            end
          end
        end
      end
      ST_WSET: begin
        st_nxt  = ST_WPUL;
        ph_load = 1'b1;
        ph_val  = PH_W'(WP_CYC - 1);
      end
      ST_WPUL: begin
        if (ph_zero) begin
          st_nxt  = ST_WREC;
          ph_load = 1'b1;
          ph_val  = PH_W'(REC_CYC - 1);
        end
      end
      ST_WREC: begin
        if (ph_zero) st_nxt = ST_IDLE;
      end
      ST_RACC: begin
        if (ph_zero) begin
          st_nxt   = ST_IDLE;
          capture  = 1'b1;
          gap_load = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins import asram_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  asram_st_e         st_nxt,
  input  logic              accept,
  input  logic              start,
  input  logic              null_rd,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [LANES-1:0]  be_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ack
);

  logic nxt_idle;
  assign nxt_idle = (st_nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      ack      <= 1'b0;
      rd_valid <= 1'b0;
      addr     <= '0;
    end else begin
      cs_n     <= nxt_idle;
      oe_n     <= (st_nxt != ST_RACC);
      we_n     <= (st_nxt != ST_WPUL);
      dq_oe    <= (st_nxt == ST_WPUL);
      ack      <= accept;
      rd_valid <= capture | null_rd;
      if (start) addr <= req_addr;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic sel_q;
    logic sel_nxt;

    assign sel_nxt = start ? req_mask[i] : sel_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q              <= 1'b0;
        be_n[i]            <= 1'b1;
        dq_out[8*i +: 8]   <= '0;
        rd_data[8*i +: 8]  <= '0;
      end else begin
        sel_q   <= sel_nxt;
        be_n[i] <= nxt_idle ? 1'b1 : !sel_nxt;
        if (start) dq_out[8*i +: 8] <= req_wdata[8*i +: 8];
        if (capture)      rd_data[8*i +: 8] <= sel_q ? dq_in[8*i +: 8] : 8'h00;
        else if (null_rd) rd_data[8*i +: 8] <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl import asram_pkg::*; #(
  parameter int CLK_NS  = 5,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int T_RC_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                req_ack,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_cs_n,
  output logic                sram_oe_n,
  output logic                sram_we_n,
  output logic [DATA_W/8-1:0] sram_be_n,
  output logic [DATA_W-1:0]   sram_dq_out,
  output logic                sram_dq_oe,
  input  logic [DATA_W-1:0]   sram_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
  localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC = imax(1, WC_CYC - WP_CYC - 1);
  localparam int TA_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int MAXC    = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
  localparam int PH_W    = $clog2(MAXC + 1);

  asram_st_e       st_nxt;
  logic            ph_load, ph_zero, gap_load, gap_zero;
  logic [PH_W-1:0] ph_val;
  logic            accept, start, null_rd, capture;
  logic            req_null;

  assign req_null = (req_mask == '0);

  asram_seq #(
    .PH_W   (PH_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_null (req_null),
    .ack_q    (req_ack),
    .gap_zero (gap_zero),
    .ph_zero  (ph_zero),
    .st_nxt   (st_nxt),
    .ph_load  (ph_load),
    .ph_val   (ph_val),
    .gap_load (gap_load),
    .accept   (accept),
    .start    (start),
    .null_rd  (null_rd),
    .capture  (capture)
  );

  asram_tmr #(.W(PH_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .load(ph_load),
    .val (ph_val),
    .zero(ph_zero)
  );

  asram_tmr #(.W(PH_W)) u_float (
    .clk (clk),
    .rst (rst),
    .load(gap_load),
    .val (PH_W'(TA_CYC)),
    .zero(gap_zero)
  );

  asram_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .st_nxt   (st_nxt),
    .accept   (accept),
    .start    (start),
    .null_rd  (null_rd),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .dq_in    (sram_dq_in),
    .cs_n     (sram_cs_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .be_n     (sram_be_n),
    .addr     (sram_addr),
    .dq_out   (sram_dq_out),
    .dq_oe    (sram_dq_oe),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ack      (req_ack)
  );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
`timescale 1ns/1ps
module async_sram_ctrl_chk #(
  parameter int RD_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int TA_CYC = 1,
  parameter int LANES  = 2,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [LANES-1:0]  be_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe,
  input logic              req_ack,
  input logic              rd_valid
);

  logic [7:0] we_lo;
  logic [7:0] oe_lo;
  logic [7:0] since_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo    <= '0;
      oe_lo    <= '0;
      since_oe <= 8'hFF;
    end else begin
      if (we_n) we_lo <= '0;
      else if (we_lo != 8'hFF) we_lo <= we_lo + 8'd1;
      if (oe_n) oe_lo <= '0;
      else if (oe_lo != 8'hFF) oe_lo <= oe_lo + 8'd1;
      if (!oe_n) since_oe <= '0;
      else if (since_oe != 8'hFF) since_oe <= since_oe + 8'd1;
    end
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> ((&be_n) && oe_n && we_n && !dq_oe));

  p_read_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (oe_lo == 8'(RD_CYC)));

  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_lo == 8'(WP_CYC)));

  p_we_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> !$past(cs_n));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !cs_n));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> ($stable(addr) && $stable(be_n)));

  p_float_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (since_oe >= 8'(TA_CYC)));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
  .RD_CYC(RD_CYC),
  .WP_CYC(WP_CYC),
  .TA_CYC(TA_CYC),
  .LANES (LANES),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (sram_cs_n),
  .oe_n    (sram_oe_n),
  .we_n    (sram_we_n),
  .be_n    (sram_be_n),
  .addr    (sram_addr),
  .dq_oe   (sram_dq_oe),
  .req_ack (req_ack),
  .rd_valid(rd_valid)
);

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/1ps
module async_sram_ctrl_test;

  localparam int CLK_NS = 5;
  localparam int TRC = 70, TWC = 70, TWP = 55, TDW = 30, THZ = 25;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_E  = cyc(TRC);
  localparam int WP_E  = (cyc(TWP) > cyc(TDW)) ? cyc(TWP) : cyc(TDW);
  localparam int REC_E = (cyc(TWC) - WP_E - 1 > 1) ? (cyc(TWC) - WP_E - 1) : 1;
  localparam int TA_E  = cyc(THZ);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ack, rd_valid;
  logic [15:0] rd_data, sram_addr, sram_dq_out, sram_dq_in;
  logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_be_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit prev_rd = 1'b0;

  logic [15:0] ram  [0:63];
  logic [15:0] shad [0:63];

  always #2.5 clk = ~clk;

  async_sram_ctrl #(
    .CLK_NS(CLK_NS), .ADDR_W(16), .DATA_W(16),
    .T_RC_NS(TRC), .T_WC_NS(TWC), .T_WP_NS(TWP), .T_DW_NS(TDW), .T_HZ_NS(THZ)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // memory model: unselected lanes float to a visible junk pattern
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_be_n[i])
        sram_dq_in[8*i +: 8] = ram[sram_addr[5:0]][8*i +: 8];
      else
        sram_dq_in[8*i +: 8] = 8'hEE;
    end
  end

  always @(posedge clk) begin
    if (!sram_cs_n && !sram_we_n && sram_dq_oe) begin
      for (int i = 0; i < 2; i++)
        if (!sram_be_n[i]) ram[sram_addr[5:0]][8*i +: 8] <= sram_dq_out[8*i +: 8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    int waits, nset, npul, nrec, nrd, cyc_n;
    int bad_addr, bad_lane, bad_drv, bad_ctl;
    bit rv_early;
    int exp_wait;
    logic [15:0] exp_rd;
    exp_wait = (wr && prev_rd) ? TA_E + 1 : 1;
    exp_rd = {m[1] ? shad[a[5:0]][15:8] : 8'h00, m[0] ? shad[a[5:0]][7:0] : 8'h00};
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!req_ack && waits < 200);
    req_valid = 1'b0;
    if (wr && prev_rd) chk("R9 write after read ack latency", waits, exp_wait);
    else               chk("R10 ack latency", waits, exp_wait);
    if (m == 2'b00) begin
      chk("R11 null keeps cs high", sram_cs_n, 1);
      if (!wr) begin
        chk("R11 null read valid", rd_valid, 1);
        chk("R11 null read data", rd_data, 0);
      end
      @(negedge clk);
      chk("R11 null stays deselected", sram_cs_n, 1);
      chk("R10 ack one cycle", req_ack, 0);
      prev_rd = 1'b0;
      return;
    end
    nset = 0; npul = 0; nrec = 0; nrd = 0; cyc_n = 0;
    bad_addr = 0; bad_lane = 0; bad_drv = 0; bad_ctl = 0; rv_early = 1'b0;
    while (!sram_cs_n && cyc_n < 100) begin
      if (cyc_n == 1) chk("R10 ack one cycle", req_ack, 0);
      if (sram_addr !== a) bad_addr++;
      if (sram_be_n !== ~m) bad_lane++;
      if (rd_valid) rv_early = 1'b1;
      if (wr) begin
        if (!sram_oe_n) bad_ctl++;
        if (!sram_we_n) begin
          npul++;
          if (!sram_dq_oe || sram_dq_out !== d) bad_drv++;
        end else begin
          if (sram_dq_oe) bad_drv++;
          if (npul == 0) nset++;
          else nrec++;
        end
      end else begin
        if (sram_oe_n || !sram_we_n || sram_dq_oe) bad_ctl++;
        else nrd++;
      end
      cyc_n++;
      @(negedge clk);
    end
    chk("R8 address held", bad_addr, 0);
    chk("R2 deselect after access",
        {sram_be_n, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b11110);
    if (wr) begin
      chk("R5 setup cycles", nset, 1);
      chk("R5 strobe cycles", npul, WP_E);
      chk("R5 recovery cycles", nrec, REC_E);
      chk("R6 bus drive", bad_drv, 0);
      chk("R7 write lanes", bad_lane, 0);
      chk("R6 no output enable in write", bad_ctl, 0);
      for (int i = 0; i < 2; i++)
        if (m[i]) shad[a[5:0]][8*i +: 8] = d[8*i +: 8];
    end else begin
      chk("R3 read strobe cycles", nrd, RD_E);
      chk("R3 read control pins", bad_ctl, 0);
      chk("R3 read lanes", bad_lane, 0);
      chk("R4 no early valid", rv_early, 0);
      chk("R4 valid after read", rd_valid, 1);
      chk("R4 read data", rd_data, exp_rd);
    end
    prev_rd = !wr;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ram[i]  = 16'(i * 16'h0101) ^ 16'hA55A;
      shad[i] = 16'(i * 16'h0101) ^ 16'hA55A;
    end
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 reset pins",
        {sram_cs_n, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe, req_ack, rd_valid},
        8'b11111000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset",
        {sram_cs_n, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe, req_ack, rd_valid},
        8'b11111000);
    for (int a = 0; a < 32; a++) begin
      for (int m = 1; m < 4; m++)
        access(1'b1, 16'(a), 16'((a * 16'h1357) ^ (m * 16'h2121)), 2'(m));
      for (int m = 1; m < 4; m++)
        access(1'b0, 16'(a), 16'h0000, 2'(m));
    end
    // R11: zero-mask requests leave the word untouched
    access(1'b1, 16'd5, 16'hFFFF, 2'b00);
    access(1'b0, 16'd5, 16'h0000, 2'b00);
    access(1'b0, 16'd5, 16'h0000, 2'b11);
    // R9: read after read is not delayed; write after read is
    access(1'b0, 16'd40, 16'h0000, 2'b01);
    access(1'b0, 16'd41, 16'h0000, 2'b10);
    access(1'b1, 16'd41, 16'hC3D2, 2'b10);
    access(1'b0, 16'd41, 16'h0000, 2'b11);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule